// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

A watchdog timer on a simple register bus: a byte address, a write-data word, a write strobe and a read-data word that follows the address without a clock. A counter runs up one step per clock while the watchdog is enabled. When it reaches the programmed limit, the block raises a one-cycle reset request and starts again from zero. Software keeps the counter away from the limit by writing an ordered pair of 16-bit key words to the key register. A request is also raised when that service arrives too early while a minimum-service window is programmed.

The limit, the window and the control bits can be changed only after a second, different pair of key words has been written to the same key register. That pair opens the configuration registers for a fixed number of cycles. A write to the control register applies the new control bits and closes the opening at once. Status bits show whether the configuration is open and whether a written configuration has taken effect. If a configuration is applied with its reconfiguration permission cleared, the block refuses every later unlock until it is reset.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the control word reads 0x20 (watchdog off, permission bit 5 set, status bits 11 and 10 clear), the counter reads 0, the limit reads 0x400, the window reads 0, and `wdt_rst_req` is low.
- R2: Writing 0xC520 and then 0xD928 to the key register at byte offset 0x04 opens the configuration, and bit 11 of the control word at offset 0x00 then reads 1.
- R3: The second word of a key pair must come with the very next write to offset 0x04. Any other value there abandons the pair and has no effect, so C520,1234,D928 does not open the configuration and A602,0000,B480 does not clear the counter.
- R4: The configuration stays open for exactly 128 clock cycles after the unlock write. Writes to the limit (offset 0x08), the window (offset 0x0C) or the control word while it is closed are ignored.
- R5: A control write while the configuration is open loads the enable from bit 7 and the permission from bit 5. It closes the configuration (bit 11 reads 0) and sets bit 10, which reads 1 until the next unlock.
- R6: While the watchdog is enabled, the counter rises by one each cycle. When it equals the limit T, `wdt_rst_req` is high for one cycle and the counter restarts from 0, so the requests come every T+1 cycles.
- R7: Writing 0xA602 and then 0xB480 to offset 0x04 returns the counter to 0 in the cycle of the second write.
- R8: With a nonzero window W, a completed service while the counter is below W raises `wdt_rst_req` in the next cycle. A service with the counter at or above W raises no request.
- R9: Once a control word with bit 5 clear has been applied, every later unlock pair is refused (bit 11 stays 0 and limit writes stay ignored) until reset.
- R10: While the watchdog is disabled, the counter holds at 0 and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout or early service |

## Verification
Several properties are checked on every cycle. A timeout match is followed by a request and a cleared counter, and an early service is followed by a request. A granted unlock opens the configuration, a control write closes it, a closed configuration keeps the limit unchanged, and a disabled watchdog keeps its counter at zero. Some behaviour only the bench scenarios can show. These are the exact request period for each limit in the sweep and the 128-cycle length of the opening. They also include the effect of abandoned key pairs on the counter and the status bits, and the permanent refusal after permission has been withdrawn.

// File: rtl/kw_pkg.sv
package kw_pkg;
  localparam int CNT_W = 16;

  localparam logic [15:0] KEY_SVC_A  = 16'hA602;
  localparam logic [15:0] KEY_SVC_B  = 16'hB480;
  localparam logic [15:0] KEY_OPEN_A = 16'hC520;
  localparam logic [15:0] KEY_OPEN_B = 16'hD928;

  localparam int BIT_EN    = 7;
  localparam int BIT_ALLOW = 5;
  localparam int BIT_DONE  = 10;
  localparam int BIT_OPEN  = 11;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SVC  = 2'd1,
    SEQ_OPEN = 2'd2
  } seq_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_KEY  = 2'd1,
    REG_LIM  = 2'd2,
    REG_WIN  = 2'd3
  } reg_e;

  function automatic logic early_service(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] win);
    return (win != '0) && (cnt < win);
  endfunction

  function automatic logic limit_match(input logic en,
                                       input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] lim);
    return en && (cnt == lim);
  endfunction
endpackage

// File: rtl/kw_keyseq.sv
module kw_keyseq
  import kw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [15:0] key_val,
  output logic        svc_ev,
  output logic        open_ev
);
  seq_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    svc_ev  = 1'b0;
    open_ev = 1'b0;
    if (key_we) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (key_val == KEY_SVC_A)       st_d = SEQ_SVC;
          else if (key_val == KEY_OPEN_A) st_d = SEQ_OPEN;
        end
        SEQ_SVC: begin
          st_d   = SEQ_IDLE;
          svc_ev = (key_val == KEY_SVC_B);
        end
        SEQ_OPEN: begin
          st_d    = SEQ_IDLE;
          open_ev = (key_val == KEY_OPEN_B);
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/kw_unlock.sv
module kw_unlock #(
  parameter int OPEN_CYC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic allow,
  input  logic ctrl_wr,
  output logic open_grant,
  output logic is_open
);
  localparam int OW = $clog2(OPEN_CYC + 1);
  logic [OW-1:0] left_q;

  assign open_grant = open_req && allow;
  assign is_open    = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  left_q <= '0;
    else if (ctrl_wr && is_open) left_q <= '0;
    else if (open_grant)         left_q <= OW'(OPEN_CYC);
    else if (is_open)            left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/kw_counter.sv
module kw_counter
  import kw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] lim,
  input  logic [CNT_W-1:0] win,
  input  logic             svc,
  output logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic             viol,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign hit  = limit_match(en, cnt_q, lim);
  assign viol = en && svc && early_service(cnt_q, win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= hit || viol;
      if (!en || hit || svc) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
  import kw_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 32,
  parameter int OPEN_CYC = 128,
  parameter int LIM_RST  = 'h400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic          wdt_rst_req
);
  reg_e             sel;
  logic             wr_ctrl, wr_key, wr_lim, wr_win;
  logic             svc_ev, open_ev, open_grant, is_open;
  logic             en_q, allow_q, done_q;
  logic [CNT_W-1:0] lim_q, win_q, cnt;
  logic             hit, viol;
  wire              unused_bits = ^{bus_wdata[DW-1:CNT_W], bus_addr[1:0]};

  assign sel     = reg_e'(bus_addr[3:2]);
  assign wr_ctrl = bus_we && (sel == REG_CTRL);
  assign wr_key  = bus_we && (sel == REG_KEY);
  assign wr_lim  = bus_we && (sel == REG_LIM);
  assign wr_win  = bus_we && (sel == REG_WIN);

  kw_keyseq u_seq (
    .clk(clk), .rst_n(rst_n), .key_we(wr_key), .key_val(bus_wdata[15:0]),
    .svc_ev(svc_ev), .open_ev(open_ev)
  );

  kw_unlock #(.OPEN_CYC(OPEN_CYC)) u_unl (
    .clk(clk), .rst_n(rst_n), .open_req(open_ev), .allow(allow_q),
    .ctrl_wr(wr_ctrl), .open_grant(open_grant), .is_open(is_open)
  );

  kw_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .lim(lim_q), .win(win_q),
    .svc(svc_ev), .cnt(cnt), .hit(hit), .viol(viol), .rst_req(wdt_rst_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      allow_q <= 1'b1;
      done_q  <= 1'b0;
      lim_q   <= CNT_W'(LIM_RST);
      win_q   <= '0;
    end else begin
      if (open_grant) done_q <= 1'b0;
      if (wr_ctrl && is_open) begin
        en_q    <= bus_wdata[BIT_EN];
        allow_q <= bus_wdata[BIT_ALLOW];
        done_q  <= 1'b1;
      end
      if (wr_lim && is_open) lim_q <= bus_wdata[CNT_W-1:0];
      if (wr_win && is_open) win_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      REG_CTRL: begin
        bus_rdata[BIT_EN]    = en_q;
        bus_rdata[BIT_ALLOW] = allow_q;
        bus_rdata[BIT_DONE]  = done_q;
        bus_rdata[BIT_OPEN]  = is_open;
      end
      REG_KEY: bus_rdata[CNT_W-1:0] = cnt;
      REG_LIM: bus_rdata[CNT_W-1:0] = lim_q;
      REG_WIN: bus_rdata[CNT_W-1:0] = win_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kw_chk.sv
module kw_chk
  import kw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             allow,
  input logic             is_open,
  input logic             open_grant,
  input logic             wr_ctrl,
  input logic             wr_lim,
  input logic [CNT_W-1:0] lim,
  input logic [CNT_W-1:0] cnt,
  input logic             hit,
  input logic             viol,
  input logic             rst_req
);
  // R6
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (rst_req && cnt == '0));
  // R8
  early_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> rst_req);
  // R2
  unlock_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_grant |=> is_open);
  // R5
  ctrl_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && is_open) |=> !is_open);
  // R4
  locked_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lim && !is_open) |=> $stable(lim));
  // R9
  refused_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow && !is_open) |=> !is_open);
  // R10
  idle_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

bind keyguard_wdt kw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .allow(allow_q), .is_open(is_open),
  .open_grant(open_grant), .wr_ctrl(wr_ctrl), .wr_lim(wr_lim), .lim(lim_q),
  .cnt(cnt), .hit(hit), .viol(viol), .rst_req(wdt_rst_req)
);

// File: tb/keyguard_wdt_tb.sv
`timescale 1ns/1ps
module keyguard_wdt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int nvec = 0;
  int nbad = 0;
  logic mon = 1'b0;
  logic seen = 1'b0;

  always #10 clk = ~clk;

  keyguard_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  always @(posedge clk) if (mon && wdt_rst_req) seen <= 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(4'h4, 32'hC520);
    wr(4'h4, 32'hD928);
  endtask

  task automatic service();
    wr(4'h4, 32'hA602);
    wr(4'h4, 32'hB480);
  endtask

  function automatic logic [31:0] ctrl_word(input logic en, input logic allow,
                                            input logic done, input logic open);
    return (32'(open) << 11) | (32'(done) << 10) | (32'(en) << 7) | (32'(allow) << 5);
  endfunction

  task automatic cfg(input logic en, input logic allow, input int lim, input int win);
    unlock();
    wr(4'h0, ctrl_word(1'b0, 1'b1, 1'b0, 1'b0));
    unlock();
    wr(4'h8, 32'(lim));
    wr(4'hC, 32'(win));
    wr(4'h0, ctrl_word(en, allow, 1'b0, 1'b0));
  endtask

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, d); chk("R1 ctrl", d, 32'h20);
    rd(4'h4, d); chk("R1 counter", d, 0);
    rd(4'h8, d); chk("R1 limit", d, 32'h400);
    rd(4'hC, d); chk("R1 window", d, 0);
    chk("R1 request", 32'(wdt_rst_req), 0);

    // R2 unlock and R4 window length
    unlock();
    rd(4'h0, d); chk("R2 open bit", d, ctrl_word(1'b0, 1'b1, 1'b0, 1'b1));
    repeat (127) @(negedge clk);
    rd(4'h0, d); chk("R4 open at 127", 32'(d[11]), 1);
    @(negedge clk);
    rd(4'h0, d); chk("R4 closed at 128", 32'(d[11]), 0);
    wr(4'h8, 32'h55);
    rd(4'h8, d); chk("R4 locked limit write", d, 32'h400);
    wr(4'hC, 32'h9);
    rd(4'hC, d); chk("R4 locked window write", d, 0);
    wr(4'h0, 32'h80);
    rd(4'h0, d); chk("R4 locked ctrl write", d, 32'h20);

    // R6 sweep of the limit, R5 status after apply
    for (int t = 1; t <= 8; t++) begin
      int n;
      cfg(1'b1, 1'b1, t, 0);
      rd(4'h0, d); chk("R5 applied status", d, ctrl_word(1'b1, 1'b1, 1'b1, 1'b0));
      n = 0;
      do begin @(negedge clk); n++; end while (!wdt_rst_req && n < 100);
      chk("R6 first period", 32'(n), 32'(t + 1));
      n = 0;
      do begin @(negedge clk); n++; end while (!wdt_rst_req && n < 100);
      chk("R6 next period", 32'(n), 32'(t + 1));
      @(negedge clk);
      chk("R6 single-cycle request", 32'(wdt_rst_req), 0);
    end

    // R7 service keeps it alive
    cfg(1'b1, 1'b1, 20, 0);
    seen = 1'b0; mon = 1'b1;
    for (int k = 0; k < 10; k++) begin
      repeat (10) @(negedge clk);
      service();
      rd(4'h4, d); chk("R7 counter cleared", d, 0);
    end
    mon = 1'b0;
    chk("R7 no request while serviced", 32'(seen), 0);

    // R3 abandoned pairs
    wr(4'h4, 32'hA602); wr(4'h4, 32'h0000); wr(4'h4, 32'hB480);
    rd(4'h4, d); chk("R3 service pair abandoned", d, 3);
    wr(4'h4, 32'hC520); wr(4'h4, 32'h1234); wr(4'h4, 32'hD928);
    rd(4'h0, d); chk("R3 unlock pair abandoned", 32'(d[11]), 0);

    // R8 windowed service
    cfg(1'b1, 1'b1, 40, 5);
    service();
    chk("R8 early service request", 32'(wdt_rst_req), 1);
    repeat (10) @(negedge clk);
    service();
    chk("R8 late service no request", 32'(wdt_rst_req), 0);
    rd(4'h4, d); chk("R8 counter cleared", d, 0);

    // R10 disabled
    cfg(1'b0, 1'b1, 3, 0);
    seen = 1'b0; mon = 1'b1;
    repeat (12) @(negedge clk);
    mon = 1'b0;
    chk("R10 no request while off", 32'(seen), 0);
    rd(4'h4, d); chk("R10 counter held", d, 0);

    // R9 permission withdrawn
    cfg(1'b0, 1'b0, 3, 0);
    rd(4'h0, d); chk("R9 applied status", d, ctrl_word(1'b0, 1'b0, 1'b1, 1'b0));
    unlock();
    rd(4'h0, d); chk("R9 unlock refused", 32'(d[11]), 0);
    wr(4'h8, 32'h77);
    rd(4'h8, d); chk("R9 limit unchanged", d, 3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule